// File: doc/BRIEF.md
# Video Test Pattern Stream Source

This block produces synthetic video frames as an AXI4-Stream of 24-bit RGB pixels, in raster order, for a downstream stream-to-video converter. A small write-only configuration port sets the frame width, frame height and background pattern, and a control word starts generation. After a start, exactly one frame is sent. If the auto-restart bit is set, frames follow back to back with no idle cycle between them. The first pixel of every frame carries TUSER and the last pixel of every line carries TLAST.

Five backgrounds are available: eight vertical colour bars, a horizontal ramp, a diagonal (horizontal plus vertical) ramp, a checkerboard and a rainbow gradient. Configuration writes go into staging registers. Those values are copied into the generator only when a frame begins, so a frame in flight never changes shape. The output stream honours TREADY backpressure.

Top module: `pattern_stream_src`

## Requirements
- R1: After reset, `m_tvalid`, `m_tuser`, `m_tlast` and `frame_done` are 0. Width and height default to 640 and 480, and the pattern defaults to code 0.
- R2: The configuration register addresses are 0 for control, 1 for width, 2 for height and 3 for pattern. In the control word, bit 0 requests a frame and bit 7 is auto-restart. A control write with any other bit set is ignored entirely. Width and height must be at least 1.
- R3: Pixels are sent row by row, left to right. TUSER is 1 only on pixel (0,0). TLAST is 1 only where x = width-1. TDATA packs red in [23:16], green in [15:8] and blue in [7:0].
- R4: The pixel position advances only on a cycle where TVALID and TREADY are both 1. While TVALID=1 and TREADY=0, TVALID, TDATA, TUSER and TLAST hold their values.
- R5: Pattern code 0 gives colour bars. The band is floor(8·x/width), and bands 0 to 7 are white, yellow, cyan, green, magenta, red, blue and black, each channel either 00 or FF.
- R6: Pattern code 1 gives a horizontal ramp: all three channels equal x mod 256.
- R7: Pattern code 2 gives a diagonal ramp: all three channels equal (x+y) mod 256.
- R8: Pattern code 3 gives a checkerboard of 8×8 cells. A pixel is white when floor(x/8)+floor(y/8) is odd and black otherwise.
- R9: Pattern code 4 gives a rainbow: R = x mod 256, G = y mod 256, B = 255 − (x mod 256). Any other code gives black.
- R10: Without auto-restart, `frame_done` goes to 1 on the edge of the last handshake of a frame. TVALID then stays 0 until a new start request. `frame_done` clears when the next frame begins.
- R11: With auto-restart set at the last handshake, the first pixel of the next frame is valid in the following cycle. Clearing auto-restart during a frame lets that frame finish and then stops.
- R12: Writes to width, height or pattern made during a frame do not affect that frame. They apply from the next frame onward.
- R13: A start request written while a frame runs is held, and one more frame follows the current one. A start request that lands on the edge of the final handshake causes exactly one idle cycle with `frame_done`=1, and then the frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 12 | Configuration write data |
| m_tdata | output | 24 | Pixel colour, R/G/B |
| m_tvalid | output | 1 | Pixel valid |
| m_tready | input | 1 | Downstream ready |
| m_tuser | output | 1 | Start of frame |
| m_tlast | output | 1 | End of line |
| frame_done | output | 1 | Frame finished with no follow-on frame |

## Verification
The sensitive coincidence is the final handshake of a frame arriving on the same edge as a control write. Two cases are tested: clearing auto-restart on that edge, and requesting a start on that edge. In both cases the bench holds TREADY high so that the edge is known exactly. It then checks the cycle after: either TVALID and TUSER with no gap, or one cycle of `frame_done` with TVALID low followed by a fresh frame. Every pixel in both cases is compared against the scoreboard.

// File: rtl/tpgs_pkg.sv
package tpgs_pkg;
  parameter int DIM_W     = 12;
  parameter int COL_W     = 8;
  parameter int BAND_LOG2 = 3;
  parameter int CELL_LOG2 = 3;
  localparam int PIX_W    = 3 * COL_W;

  typedef logic [DIM_W-1:0] dim_t;
  typedef logic [PIX_W-1:0] pix_t;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_WIDTH  = 2'd1;
  localparam logic [1:0] A_HEIGHT = 2'd2;
  localparam logic [1:0] A_PAT    = 2'd3;

  localparam int CTRL_GO   = 0;
  localparam int CTRL_AUTO = 7;

  localparam dim_t P_BARS    = dim_t'(0);
  localparam dim_t P_HRAMP   = dim_t'(1);
  localparam dim_t P_HVRAMP  = dim_t'(2);
  localparam dim_t P_CHECK   = dim_t'(3);
  localparam dim_t P_RAINBOW = dim_t'(4);

  // expand one bit per channel into a full-scale colour
  function automatic pix_t rgb_bits(input logic [2:0] b);
    return {{COL_W{b[2]}}, {COL_W{b[1]}}, {COL_W{b[0]}}};
  endfunction

  // band index = floor(2^BAND_LOG2 * x / w)
  function automatic logic [BAND_LOG2-1:0] bar_band(input dim_t x, input dim_t w);
    logic [DIM_W+BAND_LOG2-1:0] num, den, q;
    num = {x, {BAND_LOG2{1'b0}}};
    den = {{BAND_LOG2{1'b0}}, w};
    q   = num / den;
    return q[BAND_LOG2-1:0];
  endfunction

  function automatic pix_t bar_colour(input logic [2:0] band);
    case (band)
      3'd0: return rgb_bits(3'b111);
      3'd1: return rgb_bits(3'b110);
      3'd2: return rgb_bits(3'b011);
      3'd3: return rgb_bits(3'b010);
      3'd4: return rgb_bits(3'b101);
      3'd5: return rgb_bits(3'b100);
      3'd6: return rgb_bits(3'b001);
      default: return rgb_bits(3'b000);
    endcase
  endfunction

  function automatic pix_t pattern_pixel(input dim_t pat, input dim_t x,
                                         input dim_t y, input dim_t w);
    dim_t s;
    logic odd;
    s   = x + y;
    odd = x[CELL_LOG2] ^ y[CELL_LOG2];
    case (pat)
      P_BARS:    return bar_colour(3'(bar_band(x, w)));
      P_HRAMP:   return {3{x[COL_W-1:0]}};
      P_HVRAMP:  return {3{s[COL_W-1:0]}};
      P_CHECK:   return rgb_bits({3{odd}});
      P_RAINBOW: return {x[COL_W-1:0], y[COL_W-1:0], ~x[COL_W-1:0]};
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/tpgs_cfg.sv
module tpgs_cfg
  import tpgs_pkg::*;
#(
  parameter int DEF_W = 640,
  parameter int DEF_H = 480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [DIM_W-1:0] wdata,
  input  logic             frame_begin,
  output logic             auto_on,
  output logic             start_pend,
  output dim_t             act_w,
  output dim_t             act_h,
  output dim_t             act_pat
);
  localparam dim_t CTRL_MASK = dim_t'((1 << CTRL_GO) | (1 << CTRL_AUTO));

  dim_t stg_w, stg_h, stg_pat;
  logic ctrl_ok;

  assign ctrl_ok = we && (addr == A_CTRL) && ((wdata & ~CTRL_MASK) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_w      <= dim_t'(DEF_W);
      stg_h      <= dim_t'(DEF_H);
      stg_pat    <= P_BARS;
      auto_on    <= 1'b0;
      start_pend <= 1'b0;
    end else begin
      if (we && addr == A_WIDTH)  stg_w   <= wdata;
      if (we && addr == A_HEIGHT) stg_h   <= wdata;
      if (we && addr == A_PAT)    stg_pat <= wdata;
      if (frame_begin) start_pend <= 1'b0;
      if (ctrl_ok) begin
        auto_on <= wdata[CTRL_AUTO];
        if (wdata[CTRL_GO]) start_pend <= 1'b1;
      end
    end
  end

  // geometry and pattern used by the generator, frozen per frame
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_w   <= dim_t'(DEF_W);
      act_h   <= dim_t'(DEF_H);
      act_pat <= P_BARS;
    end else if (frame_begin) begin
      act_w   <= stg_w;
      act_h   <= stg_h;
      act_pat <= stg_pat;
    end
  end
endmodule

// File: rtl/tpgs_raster.sv
module tpgs_raster
  import tpgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  input  dim_t w,
  input  dim_t h,
  output dim_t x,
  output dim_t y,
  output logic line_end,
  output logic frame_end
);
  assign line_end  = (x == w - dim_t'(1));
  assign frame_end = line_end && (y == h - dim_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (load) begin
      x <= '0;
      y <= '0;
    end else if (adv) begin
      if (line_end) begin
        x <= '0;
        y <= y + dim_t'(1);
      end else begin
        x <= x + dim_t'(1);
      end
    end
  end
endmodule

// File: rtl/tpgs_colour.sv
module tpgs_colour
  import tpgs_pkg::*;
(
  input  dim_t pat,
  input  dim_t x,
  input  dim_t y,
  input  dim_t w,
  output pix_t pix
);
  assign pix = pattern_pixel(pat, x, y, w);
endmodule

// File: rtl/pattern_stream_src.sv
module pattern_stream_src
  import tpgs_pkg::*;
#(
  parameter int DEF_W = 640,
  parameter int DEF_H = 480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DIM_W-1:0] cfg_wdata,
  output logic [PIX_W-1:0] m_tdata,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic             m_tuser,
  output logic             m_tlast,
  output logic             frame_done
);
  logic run_q, done_q;
  logic auto_on, start_pend;
  dim_t act_w, act_h, act_pat, x, y;
  logic line_end, frame_end;
  pix_t pix;

  // named events, also watched by the checker
  logic px_fire, frame_begin, keep_going;

  assign px_fire     = run_q && m_tready;
  assign keep_going  = auto_on || start_pend;
  assign frame_begin = (!run_q && start_pend) || (px_fire && frame_end && keep_going);

  tpgs_cfg #(.DEF_W(DEF_W), .DEF_H(DEF_H)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_begin(frame_begin), .auto_on(auto_on), .start_pend(start_pend),
    .act_w(act_w), .act_h(act_h), .act_pat(act_pat)
  );

  tpgs_raster u_raster (
    .clk(clk), .rst_n(rst_n), .load(frame_begin), .adv(px_fire),
    .w(act_w), .h(act_h), .x(x), .y(y),
    .line_end(line_end), .frame_end(frame_end)
  );

  tpgs_colour u_colour (
    .pat(act_pat), .x(x), .y(y), .w(act_w), .pix(pix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (frame_begin) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (px_fire && frame_end) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign m_tvalid   = run_q;
  assign m_tdata    = pix;
  assign m_tuser    = run_q && (x == '0) && (y == '0);
  assign m_tlast    = run_q && line_end;
  assign frame_done = done_q;
endmodule

// File: rtl/pattern_stream_src_chk.sv
module pattern_stream_src_chk
  import tpgs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] m_tdata,
  input logic             m_tvalid,
  input logic             m_tready,
  input logic             m_tuser,
  input logic             m_tlast,
  input logic             frame_done,
  input logic             px_fire,
  input logic             frame_end,
  input logic             frame_begin
);
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !m_tvalid);

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> $past(px_fire && m_tlast));

  a_r11_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    px_fire && frame_end && frame_begin |=> m_tvalid && m_tuser && !frame_done);

  a_r3_frame_end_last: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && frame_end |-> m_tlast);

  a_r3_user_valid: assert property (@(posedge clk) disable iff (!rst_n)
    m_tuser |-> m_tvalid);
endmodule

bind pattern_stream_src pattern_stream_src_chk u_chk (
  .clk(clk), .rst_n(rst_n), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
  .m_tready(m_tready), .m_tuser(m_tuser), .m_tlast(m_tlast),
  .frame_done(frame_done), .px_fire(px_fire), .frame_end(frame_end),
  .frame_begin(frame_begin)
);

// File: tb/pattern_stream_src_test.sv
module pattern_stream_src_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [23:0] m_tdata;
  logic m_tvalid, m_tready, m_tuser, m_tlast, frame_done;

  always #2.5 clk = ~clk;

  pattern_stream_src uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tuser(m_tuser), .m_tlast(m_tlast),
    .frame_done(frame_done)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [25:0] expq[$];
  string cur_req = "R3";
  int popped = 0;
  bit free_ready = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit held_v = 0;
  logic [25:0] held;

  task automatic check(string req, bit ok, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] full(bit r, bit g, bit b);
    return {{8{r}}, {8{g}}, {8{b}}};
  endfunction

  function automatic logic [23:0] model(int pat, int x, int y, int w);
    int band;
    case (pat)
      0: begin
        band = 0;
        while ((band + 1) * w <= x * 8) band++;
        case (band)
          0: return full(1, 1, 1);
          1: return full(1, 1, 0);
          2: return full(0, 1, 1);
          3: return full(0, 1, 0);
          4: return full(1, 0, 1);
          5: return full(1, 0, 0);
          6: return full(0, 0, 1);
          default: return full(0, 0, 0);
        endcase
      end
      1: return {3{8'(x % 256)}};
      2: return {3{8'((x + y) % 256)}};
      3: return (((x / 8) + (y / 8)) % 2 == 1) ? 24'hFFFFFF : 24'h0;
      4: return {8'(x % 256), 8'(y % 256), 8'(255 - (x % 256))};
      default: return 24'h0;
    endcase
  endfunction

  task automatic push_frame(int w, int h, int pat);
    for (int yy = 0; yy < h; yy++)
      for (int xx = 0; xx < w; xx++)
        expq.push_back({model(pat, xx, yy, w), 1'(xx == 0 && yy == 0), 1'(xx == w - 1)});
  endtask

  task automatic cfg_write(logic [1:0] a, logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain(string req);
    int t = 0;
    while ((expq.size() != 0 || !frame_done) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(req, expq.size() == 0 && frame_done, 32'(expq.size()), 0);
    repeat (4) @(negedge clk);
    check("R10", !m_tvalid && frame_done, {m_tvalid, frame_done}, 2'b01);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      m_tready = 1'b0;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (held_v)
        check("R4", {m_tvalid, m_tdata, m_tuser, m_tlast} == {1'b1, held},
              {m_tvalid, m_tdata, m_tuser, m_tlast}, {1'b1, held});
      m_tready = free_ready ? 1'b1 : (lfsr[0] | lfsr[3]);
      held_v = m_tvalid && !m_tready;
      held = {m_tdata, m_tuser, m_tlast};
      if (m_tvalid && m_tready) begin
        if (expq.size() == 0) begin
          check("R10", 0, {m_tdata, m_tuser, m_tlast}, 0);
        end else begin
          logic [25:0] e;
          e = expq.pop_front();
          check(cur_req, {m_tdata, m_tuser, m_tlast} == e, {m_tdata, m_tuser, m_tlast}, e);
          popped++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {m_tvalid, m_tuser, m_tlast, frame_done} == 4'b0,
          {m_tvalid, m_tuser, m_tlast, frame_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {m_tvalid, frame_done} == 2'b0, {m_tvalid, frame_done}, 0);

    // R2: ctrl write with a reserved bit is ignored
    cfg_write(2'd1, 12'd4); cfg_write(2'd2, 12'd1);
    cfg_write(2'd0, 12'h003);
    repeat (6) @(negedge clk);
    check("R2", !m_tvalid, m_tvalid, 0);

    // R5 bars 64x2
    cur_req = "R5";
    cfg_write(2'd1, 12'd64); cfg_write(2'd2, 12'd2); cfg_write(2'd3, 12'd0);
    push_frame(64, 2, 0);
    cfg_write(2'd0, 12'h001);
    drain("R5");
    repeat (6) @(negedge clk);
    check("R10", !m_tvalid, m_tvalid, 0);

    cur_req = "R6";
    cfg_write(2'd1, 12'd300); cfg_write(2'd3, 12'd1);
    push_frame(300, 2, 1); cfg_write(2'd0, 12'h001); drain("R6");

    cur_req = "R7";
    cfg_write(2'd1, 12'd16); cfg_write(2'd2, 12'd20); cfg_write(2'd3, 12'd2);
    push_frame(16, 20, 2); cfg_write(2'd0, 12'h001); drain("R7");

    cur_req = "R8";
    cfg_write(2'd1, 12'd20); cfg_write(2'd3, 12'd3);
    push_frame(20, 20, 3); cfg_write(2'd0, 12'h001); drain("R8");

    cur_req = "R9";
    cfg_write(2'd1, 12'd10); cfg_write(2'd2, 12'd3); cfg_write(2'd3, 12'd4);
    push_frame(10, 3, 4); cfg_write(2'd0, 12'h001); drain("R9");
    cfg_write(2'd1, 12'd4); cfg_write(2'd2, 12'd2); cfg_write(2'd3, 12'd6);
    push_frame(4, 2, 6); cfg_write(2'd0, 12'h001); drain("R9");

    // R3 one-pixel frame: TUSER and TLAST together
    cur_req = "R3";
    cfg_write(2'd1, 12'd1); cfg_write(2'd2, 12'd1); cfg_write(2'd3, 12'd0);
    push_frame(1, 1, 0); cfg_write(2'd0, 12'h001); drain("R3");

    // R12 / R13: reconfigure and re-request during a running frame
    cur_req = "R12";
    cfg_write(2'd1, 12'd8); cfg_write(2'd2, 12'd2); cfg_write(2'd3, 12'd0);
    push_frame(8, 2, 0); push_frame(4, 2, 1);
    begin
      int p0;
      p0 = popped;
      cfg_write(2'd0, 12'h001);
      wait (popped > p0);
    end
    cfg_write(2'd1, 12'd4); cfg_write(2'd3, 12'd1); cfg_write(2'd0, 12'h001);
    drain("R13");

    // collision cases with TREADY held high
    free_ready = 1;
    cur_req = "R11";
    cfg_write(2'd1, 12'd4); cfg_write(2'd2, 12'd1); cfg_write(2'd3, 12'd3);
    push_frame(4, 1, 3); push_frame(4, 1, 3);
    cfg_write(2'd0, 12'h081);
    repeat (4) @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 12'h000;  // lands on last handshake
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11", m_tvalid && m_tuser && !frame_done, {m_tvalid, m_tuser, frame_done}, 3'b110);
    drain("R11");

    cur_req = "R13";
    push_frame(4, 1, 3); push_frame(4, 1, 3);
    cfg_write(2'd0, 12'h001);
    repeat (4) @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 12'h001;  // lands on last handshake
    @(negedge clk);
    cfg_we = 1'b0;
    check("R13", frame_done && !m_tvalid, {frame_done, m_tvalid}, 2'b10);
    @(negedge clk);
    check("R10", m_tvalid && m_tuser && !frame_done, {m_tvalid, m_tuser, frame_done}, 3'b110);
    drain("R13");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule